// File: doc/BRIEF.md
# Camera Pixel-to-Byte Output Formatter

This block sits at the end of a camera image pipeline and turns each processed pixel into two bytes on an 8-bit parallel output bus. Three output families are supported: YCbCr 4:2:2, where two neighbouring pixels share one chroma pair and four byte orderings can be chosen; RGB565, packed into two bytes with red and blue positions selectable; and raw 10-bit sensor samples, sent as a zero-padded upper byte followed by the lower eight bits.

The upstream stage presents at most one pixel every second clock, together with a start-of-line marker on the first pixel of every line. The format and ordering selects are taken only on that marker, so a line never mixes formats and a 4:2:2 pair is never split. Every accepted pixel yields exactly one byte on each of the next two clocks; at all other times the bus rests at zero with the byte strobe low.

Top module: `cam_byte_formatter`

## Requirements
- R1: After reset, byte_out is 0x00, byte_vld is low, and until the first line_start the block behaves as YCbCr (fmt_sel 0) with ordering 0 and the next pixel treated as the first of a pair.
- R2: A pixel accepted at a clock edge (pix_valid high, no byte pending) produces its first byte with byte_vld high after that edge and its second byte with byte_vld high after the following edge.
- R3: With fmt_sel 0 (YCbCr), a pixel pair gives four bytes in the order selected by ord_sel: 0 gives Y0,Cb,Y1,Cr; 1 gives Y0,Cr,Y1,Cb; 2 gives Cb,Y0,Cr,Y1; 3 gives Cr,Y0,Cb,Y1.
- R4: In YCbCr mode the chroma pair sent for a pair of pixels is the one presented with the first pixel; the chroma inputs of the second pixel have no effect on the output.
- R5: With fmt_sel 1 (RGB565) and ord_sel bit 0 clear, the first byte is {R[4:0],G[5:3]} and the second is {G[2:0],B[4:0]}.
- R6: With fmt_sel 1 and ord_sel bit 0 set, the first byte is {B[4:0],G[5:3]} and the second is {G[2:0],R[4:0]}; ord_sel bit 1 has no effect in RGB565.
- R7: With fmt_sel 2 or 3 (raw), the first byte is six zero bits followed by D[9:8] and the second is D[7:0]; ord_sel has no effect.
- R8: fmt_sel and ord_sel are taken only from a pixel accepted with line_start high; a change on a pixel without line_start has no effect.
- R9: A pixel accepted with line_start high is always the first pixel of a YCbCr pair, whatever the parity of the previous line.
- R10: When no byte is being sent, byte_out is 0x00 and byte_vld is low.
- R11: pix_valid (with any line_start, fmt_sel or ord_sel) in the cycle where a second byte is still pending is ignored: no extra bytes and no change of format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present on the component inputs |
| line_start | input | 1 | Marks the first pixel of a line |
| fmt_sel | input | 2 | 0 YCbCr, 1 RGB565, 2 or 3 raw |
| ord_sel | input | 2 | Byte ordering within the chosen format |
| pix_y | input | 8 | Luma component |
| pix_cb | input | 8 | Blue-difference chroma |
| pix_cr | input | 8 | Red-difference chroma |
| pix_r | input | 5 | Red component for RGB565 |
| pix_g | input | 6 | Green component for RGB565 |
| pix_b | input | 5 | Blue component for RGB565 |
| pix_raw | input | 10 | Raw sensor sample |
| byte_out | output | 8 | Output byte |
| byte_vld | output | 1 | Output byte is valid |

## Verification
The bench steps through every YCbCr ordering with a pair whose second pixel carries different chroma, so a design that re-sampled chroma on the second pixel or swapped orderings would emit wrong bytes in the third or fourth position. It changes the format on a mid-line pixel and on a pixel arriving while a byte is still pending; a design that applied either change at once would switch packing early or emit a third byte. Two consecutive line starts check that pair parity restarts, which a free-running parity counter would fail by sending the wrong chroma, and RGB565 with ord_sel 3 catches a design that decodes both order bits there.

// File: rtl/cfmt_pkg.sv
package cfmt_pkg;
    localparam int BYTE_W = 8;
    localparam int RAW_W  = 10;
    localparam int R_W    = 5;
    localparam int G_W    = 6;
    localparam int B_W    = 5;

    typedef enum logic [1:0] {
        FMT_YCC     = 2'd0,
        FMT_RGB     = 2'd1,
        FMT_RAW     = 2'd2,
        FMT_RAW_ALT = 2'd3
    } fmt_e;
endpackage

// File: rtl/cfmt_ycc_map.sv
module cfmt_ycc_map
    import cfmt_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [1:0]   ord,
    input  logic         odd,
    input  logic [W-1:0] y,
    input  logic [W-1:0] cb_now,
    input  logic [W-1:0] cr_now,
    input  logic [W-1:0] cb_held,
    input  logic [W-1:0] cr_held,
    output logic [W-1:0] first,
    output logic [W-1:0] second
);
    logic [W-1:0] chroma;

    always_comb begin
        // even pixel carries the chroma of ord[0], odd pixel the other one
        if (!odd) chroma = ord[0] ? cr_now  : cb_now;
        else      chroma = ord[0] ? cb_held : cr_held;
        if (!ord[1]) begin
            first  = y;
            second = chroma;
        end else begin
            first  = chroma;
            second = y;
        end
    end
endmodule

// File: rtl/cfmt_rgb_map.sv
module cfmt_rgb_map
    import cfmt_pkg::*;
(
    input  logic              swap_rb,
    input  logic [R_W-1:0]    r,
    input  logic [G_W-1:0]    g,
    input  logic [B_W-1:0]    b,
    output logic [BYTE_W-1:0] first,
    output logic [BYTE_W-1:0] second
);
    localparam int GH_W = BYTE_W - R_W;
    localparam int GL_W = G_W - GH_W;

    logic [R_W-1:0] lead;
    logic [B_W-1:0] tail;

    always_comb begin
        lead   = swap_rb ? b : r;
        tail   = swap_rb ? r : b;
        first  = {lead, g[G_W-1 -: GH_W]};
        second = {g[GL_W-1:0], tail};
    end
endmodule

// File: rtl/cfmt_raw_split.sv
module cfmt_raw_split
    import cfmt_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int RW = RAW_W
) (
    input  logic [RW-1:0] raw,
    output logic [W-1:0]  first,
    output logic [W-1:0]  second
);
    localparam int HI_W  = RW - W;
    localparam int PAD_W = W - HI_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign first = {{PAD_W{1'b0}}, raw[RW-1:W]};
        end else begin : g_nopad
            assign first = raw[RW-1 -: W];
        end
    endgenerate
    assign second = raw[W-1:0];
endmodule

// File: rtl/cam_byte_formatter.sv
module cam_byte_formatter
    import cfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              line_start,
    input  logic [1:0]        fmt_sel,
    input  logic [1:0]        ord_sel,
    input  logic [BYTE_W-1:0] pix_y,
    input  logic [BYTE_W-1:0] pix_cb,
    input  logic [BYTE_W-1:0] pix_cr,
    input  logic [R_W-1:0]    pix_r,
    input  logic [G_W-1:0]    pix_g,
    input  logic [B_W-1:0]    pix_b,
    input  logic [RAW_W-1:0]  pix_raw,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              vld;
        logic              pend;
        logic [BYTE_W-1:0] second;
        logic              odd;
        logic [BYTE_W-1:0] cb_h;
        logic [BYTE_W-1:0] cr_h;
        fmt_e              fmt;
        logic [1:0]        ord;
    } st_t;

    localparam st_t ST_RST = '{
        data: '0, vld: 1'b0, pend: 1'b0, second: '0, odd: 1'b0,
        cb_h: '0, cr_h: '0, fmt: FMT_YCC, ord: 2'd0
    };

    st_t st_d, st_q;

    fmt_e              eff_fmt;
    logic [1:0]        eff_ord;
    logic              eff_odd;
    logic              accept;
    logic [BYTE_W-1:0] ycc_b0, ycc_b1, rgb_b0, rgb_b1, raw_b0, raw_b1;

    assign accept  = pix_valid && !st_q.pend;
    assign eff_fmt = line_start ? fmt_e'(fmt_sel) : st_q.fmt;
    assign eff_ord = line_start ? ord_sel : st_q.ord;
    assign eff_odd = line_start ? 1'b0 : st_q.odd;

    cfmt_ycc_map #(.W(BYTE_W)) u_ycc (
        .ord     (eff_ord),
        .odd     (eff_odd),
        .y       (pix_y),
        .cb_now  (pix_cb),
        .cr_now  (pix_cr),
        .cb_held (st_q.cb_h),
        .cr_held (st_q.cr_h),
        .first   (ycc_b0),
        .second  (ycc_b1)
    );

    cfmt_rgb_map u_rgb (
        .swap_rb (eff_ord[0]),
        .r       (pix_r),
        .g       (pix_g),
        .b       (pix_b),
        .first   (rgb_b0),
        .second  (rgb_b1)
    );

    cfmt_raw_split #(.W(BYTE_W), .RW(RAW_W)) u_raw (
        .raw    (pix_raw),
        .first  (raw_b0),
        .second (raw_b1)
    );

    always_comb begin
        st_d      = st_q;
        st_d.data = '0;
        st_d.vld  = 1'b0;
        st_d.pend = 1'b0;
        if (st_q.pend) begin
            st_d.data = st_q.second;
            st_d.vld  = 1'b1;
        end else if (pix_valid) begin
            st_d.fmt  = eff_fmt;
            st_d.ord  = eff_ord;
            st_d.odd  = !eff_odd;
            st_d.vld  = 1'b1;
            st_d.pend = 1'b1;
            if (!eff_odd) begin
                st_d.cb_h = pix_cb;
                st_d.cr_h = pix_cr;
            end
            case (eff_fmt)
                FMT_YCC: begin
                    st_d.data   = ycc_b0;
                    st_d.second = ycc_b1;
                end
                FMT_RGB: begin
                    st_d.data   = rgb_b0;
                    st_d.second = rgb_b1;
                end
                default: begin
                    st_d.data   = raw_b0;
                    st_d.second = raw_b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign byte_out = st_q.data;
    assign byte_vld = st_q.vld;

    AST_TWO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (byte_vld ##1 byte_vld)); // R2
    AST_NO_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> !st_q.pend); // R11
    AST_RAW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.fmt[1]) |-> (byte_out[BYTE_W-1:RAW_W-BYTE_W] == '0)); // R7
    AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && line_start) |=> $stable(st_q.fmt) && $stable(st_q.ord)); // R8
    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> (byte_out == '0)); // R10
    AST_LINE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && line_start) |=> st_q.odd); // R9
endmodule

// File: tb/cam_byte_formatter_tb.sv
module cam_byte_formatter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic       line_start = 1'b0;
    logic [1:0] fmt_sel = 2'd0;
    logic [1:0] ord_sel = 2'd0;
    logic [7:0] pix_y = 8'h0, pix_cb = 8'h0, pix_cr = 8'h0;
    logic [4:0] pix_r = 5'h0, pix_b = 5'h0;
    logic [5:0] pix_g = 6'h0;
    logic [9:0] pix_raw = 10'h0;
    logic [7:0] byte_out;
    logic       byte_vld;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cam_byte_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
        .fmt_sel(fmt_sel), .ord_sel(ord_sel), .pix_y(pix_y), .pix_cb(pix_cb),
        .pix_cr(pix_cr), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_raw(pix_raw), .byte_out(byte_out), .byte_vld(byte_vld)
    );

    typedef struct packed {
        logic       ls;
        logic [1:0] fmt;
        logic [1:0] ord;
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
        logic [9:0] raw;
        logic [7:0] e0;
        logic [7:0] e1;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 2'd0, 8'h10, 8'h20, 8'h30, 5'h0, 6'h0, 5'h0, 10'h0, 8'h10, 8'h20},
        '{1'b0, 2'd0, 2'd0, 8'h11, 8'hA1, 8'hA2, 5'h0, 6'h0, 5'h0, 10'h0, 8'h11, 8'h30},
        '{1'b1, 2'd0, 2'd1, 8'h12, 8'h22, 8'h32, 5'h0, 6'h0, 5'h0, 10'h0, 8'h12, 8'h32},
        '{1'b0, 2'd0, 2'd1, 8'h13, 8'hB1, 8'hB2, 5'h0, 6'h0, 5'h0, 10'h0, 8'h13, 8'h22},
        '{1'b1, 2'd0, 2'd2, 8'h14, 8'h24, 8'h34, 5'h0, 6'h0, 5'h0, 10'h0, 8'h24, 8'h14},
        '{1'b0, 2'd0, 2'd2, 8'h15, 8'hC1, 8'hC2, 5'h0, 6'h0, 5'h0, 10'h0, 8'h34, 8'h15},
        '{1'b1, 2'd0, 2'd3, 8'h16, 8'h26, 8'h36, 5'h0, 6'h0, 5'h0, 10'h0, 8'h36, 8'h16},
        '{1'b0, 2'd0, 2'd3, 8'h17, 8'hD1, 8'hD2, 5'h0, 6'h0, 5'h0, 10'h0, 8'h26, 8'h17},
        '{1'b1, 2'd1, 2'd0, 8'h00, 8'h00, 8'h00, 5'h1B, 6'h2D, 5'h16, 10'h0, 8'hDD, 8'hB6},
        '{1'b0, 2'd1, 2'd0, 8'h00, 8'h00, 8'h00, 5'h04, 6'h3F, 5'h1F, 10'h0, 8'h27, 8'hFF},
        '{1'b1, 2'd1, 2'd1, 8'h00, 8'h00, 8'h00, 5'h1B, 6'h2D, 5'h16, 10'h0, 8'hB5, 8'hBB},
        '{1'b1, 2'd1, 2'd3, 8'h00, 8'h00, 8'h00, 5'h1B, 6'h2D, 5'h16, 10'h0, 8'hB5, 8'hBB},
        '{1'b1, 2'd2, 2'd0, 8'h00, 8'h00, 8'h00, 5'h0, 6'h0, 5'h0, 10'h2A5, 8'h02, 8'hA5},
        '{1'b0, 2'd0, 2'd2, 8'h55, 8'h66, 8'h77, 5'h0, 6'h0, 5'h0, 10'h1C3, 8'h01, 8'hC3},
        '{1'b1, 2'd3, 2'd1, 8'h00, 8'h00, 8'h00, 5'h0, 6'h0, 5'h0, 10'h3FF, 8'h03, 8'hFF},
        '{1'b1, 2'd0, 2'd0, 8'h40, 8'h50, 8'h60, 5'h0, 6'h0, 5'h0, 10'h0, 8'h40, 8'h50},
        '{1'b1, 2'd0, 2'd0, 8'h41, 8'h51, 8'h61, 5'h0, 6'h0, 5'h0, 10'h0, 8'h41, 8'h51},
        '{1'b0, 2'd0, 2'd0, 8'h42, 8'h52, 8'h62, 5'h0, 6'h0, 5'h0, 10'h0, 8'h42, 8'h61},
        '{1'b0, 2'd0, 2'd0, 8'h43, 8'h53, 8'h63, 5'h0, 6'h0, 5'h0, 10'h0, 8'h43, 8'h53}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp,
                         input logic vact, input logic vexp);
        total++;
        if (act !== exp || vact !== vexp) begin
            bad++;
            $display("FAIL %s: byte=%h vld=%b expected byte=%h vld=%b", req, act, vact, exp, vexp);
        end
    endtask

    task automatic drive(input vec_t v);
        pix_valid  = 1'b1;
        line_start = v.ls;
        fmt_sel    = v.fmt;
        ord_sel    = v.ord;
        pix_y      = v.y;
        pix_cb     = v.cb;
        pix_cr     = v.cr;
        pix_r      = v.r;
        pix_g      = v.g;
        pix_b      = v.b;
        pix_raw    = v.raw;
    endtask

    task automatic quiet();
        pix_valid  = 1'b0;
        line_start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: byte=%h vld=%b expected finish", byte_out, byte_vld);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        vec_t v;
        repeat (3) @(negedge clk);
        // R1, R10: reset state
        check("R1 reset", byte_out, 8'h00, byte_vld, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", byte_out, 8'h00, byte_vld, 1'b0);

        // R1: defaults are YCbCr order 0, first of pair, without any line_start
        v = '{1'b0, 2'd2, 2'd3, 8'h77, 8'h88, 8'h99, 5'h0, 6'h0, 5'h0, 10'h0, 8'h77, 8'h88};
        drive(v);
        @(negedge clk);
        quiet();
        check("R1 default first", byte_out, 8'h77, byte_vld, 1'b1);
        @(negedge clk);
        check("R1 default second", byte_out, 8'h88, byte_vld, 1'b1);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            quiet();
            check($sformatf("R2/R3-R9 vec%0d byte0", i), byte_out, TBL[i].e0, byte_vld, 1'b1);
            @(negedge clk);
            check($sformatf("R2/R3-R9 vec%0d byte1", i), byte_out, TBL[i].e1, byte_vld, 1'b1);
        end
        @(negedge clk);
        check("R10 idle gap", byte_out, 8'h00, byte_vld, 1'b0);

        // R11: pixel during pending second byte is ignored
        v = '{1'b1, 2'd2, 2'd0, 8'h0, 8'h0, 8'h0, 5'h0, 6'h0, 5'h0, 10'h155, 8'h01, 8'h55};
        drive(v);
        @(negedge clk);
        check("R11 raw first", byte_out, 8'h01, byte_vld, 1'b1);
        v = '{1'b1, 2'd0, 2'd0, 8'hEE, 8'hEE, 8'hEE, 5'h0, 6'h0, 5'h0, 10'h0AA, 8'h0, 8'h0};
        drive(v);
        @(negedge clk);
        quiet();
        check("R11 raw second", byte_out, 8'h55, byte_vld, 1'b1);
        @(negedge clk);
        check("R11 no extra byte", byte_out, 8'h00, byte_vld, 1'b0);
        v = '{1'b0, 2'd0, 2'd0, 8'hEE, 8'hEE, 8'hEE, 5'h0, 6'h0, 5'h0, 10'h2F0, 8'h02, 8'hF0};
        drive(v);
        @(negedge clk);
        quiet();
        check("R11 format kept first", byte_out, 8'h02, byte_vld, 1'b1);
        @(negedge clk);
        check("R11 format kept second", byte_out, 8'hF0, byte_vld, 1'b1);
        @(negedge clk);
        check("R10 idle end", byte_out, 8'h00, byte_vld, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule